// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a 32-bit processor and works out, every cycle, the address the counter moves to next. Four kinds of control flow are handled by one selector: plain sequential flow, a PC-relative branch that fires only when its condition holds, an absolute jump to a word target inside the current 256 MB region, and a jump to an address held in a source register. The decoder supplies the flow kind, the branch condition, the link selection, the 16-bit branch offset, the 26-bit jump field and the two source register values.

The same block also produces the link address (the address of the following instruction) and the number of the register that receives it. It also raises a flag when a taken transfer points at an address that is not a multiple of four. The counter itself is a register with synchronous reset to a parameter address and a stall input that freezes it.

Top module: `npc_unit`

## Requirements
- R1: When `rst` is high at a clock edge, `pc_q` takes the value `RESET_ADDR` (default 0x0040_0000), whether or not `stall` is high.
- R2: When `stall` is high and `rst` is low at a clock edge, `pc_q` keeps its value.
- R3: When both `stall` and `rst` are low at a clock edge, `pc_q` takes the value that `next_pc` showed before that edge.
- R4: With `flow_kind` = 0 (sequential), `next_pc` is `pc_q`+4 and `taken` is low, whatever the offset, jump field and register inputs are.
- R5: With `flow_kind` = 1 (branch), `next_pc` is `pc_q`+4 plus the sign-extended `br_off` shifted left by two when the condition holds, and `pc_q`+4 when it does not.
- R6: Branch conditions by `br_cond`: 0 rs equals rt, 1 rs differs from rt, 2 rs less than or equal to zero (signed), 3 rs greater than zero, 4 rs negative, 5 rs zero or positive; codes 6 and 7 never hold.
- R7: With `flow_kind` = 2 (absolute jump), `next_pc` is bits 31:28 of `pc_q`+4, then `jmp_field`, then two zero bits.
- R8: With `flow_kind` = 3 (register jump), `next_pc` is `rs_val`.
- R9: `link_sel` = 1 gives `link_we` high with `link_dst` 31; `link_sel` = 2 gives `link_we` high with `link_dst` = `rd_idx`; codes 0 and 3 give `link_we` low. While `link_we` is high, `link_addr` is `pc_q`+4, whether the branch is taken or not.
- R10: `misaligned` is high exactly when `taken` is high and bits 1:0 of `next_pc` are not both zero.
- R11: `taken` is high for every absolute or register jump and for a branch whose condition holds, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold the program counter |
| flow_kind | input | 2 | 0 sequential, 1 branch, 2 absolute jump, 3 register jump |
| br_cond | input | 3 | Branch condition code |
| link_sel | input | 2 | 0 none, 1 register 31, 2 register `rd_idx`, 3 none |
| rd_idx | input | 5 | Link destination for `link_sel` = 2 |
| br_off | input | 16 | Signed word offset of a branch |
| jmp_field | input | 26 | Word target of an absolute jump |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Address loaded at the next unstalled edge |
| taken | output | 1 | Control transfer selected |
| misaligned | output | 1 | Taken target not word aligned |
| link_addr | output | 32 | Return address to write |
| link_we | output | 1 | Link write enable |
| link_dst | output | 5 | Link destination register |

## Verification
A wrong counter state shows at `pc_q` on the edge that follows the wrong decision, and it also shifts `next_pc`, `link_addr` and every jump region at the same moment. A mistake in the condition logic or in the offset arithmetic appears at `next_pc` and `taken` in the same cycle, before any edge. The vectors place the counter with a register jump first, so each flow kind is seen from a known PC. They cover both signs of each compare, the extreme offsets, and a PC whose next instruction crosses into a new 256 MB region.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [1:0] {
      FLOW_SEQ  = 2'd0,
      FLOW_BR   = 2'd1,
      FLOW_JABS = 2'd2,
      FLOW_JREG = 2'd3
   } flow_e;

   typedef enum logic [2:0] {
      CND_EQ  = 3'd0,
      CND_NE  = 3'd1,
      CND_LEZ = 3'd2,
      CND_GTZ = 3'd3,
      CND_LTZ = 3'd4,
      CND_GEZ = 3'd5,
      CND_NV6 = 3'd6,
      CND_NV7 = 3'd7
   } cond_e;

   typedef enum logic [1:0] {
      LNK_NONE = 2'd0,
      LNK_R31  = 2'd1,
      LNK_RD   = 2'd2,
      LNK_OFF  = 2'd3
   } link_e;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int EQ_STYLE = 0
) (
   input  cond_e            cond,
   input  logic [XLEN-1:0]  rs,
   input  logic [XLEN-1:0]  rt,
   output logic             hit
);
   logic same;
   logic neg;
   logic zero;

   generate
      if (EQ_STYLE == 0) begin : g_eq_cmp
         assign same = (rs == rt);
      end else begin : g_eq_xor
         assign same = ~|(rs ^ rt);
      end
   endgenerate

   assign neg  = rs[XLEN-1];
   assign zero = ~|rs;

   always_comb begin
      case (cond)
         CND_EQ:  hit = same;
         CND_NE:  hit = ~same;
         CND_LEZ: hit = neg | zero;
         CND_GTZ: hit = ~neg & ~zero;
         CND_LTZ: hit = neg;
         CND_GEZ: hit = ~neg;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
   parameter int XLEN  = 32,
   parameter int OFF_W = 16,
   parameter int JF_W  = 26
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [OFF_W-1:0] off,
   input  logic [JF_W-1:0]  jf,
   output logic [XLEN-1:0]  seq_addr,
   output logic [XLEN-1:0]  br_addr,
   output logic [XLEN-1:0]  jabs_addr
);
   localparam int EXT_W    = XLEN - OFF_W - 2;
   localparam int REGION_W = XLEN - JF_W - 2;

   logic [XLEN-1:0] off_bytes;

   assign seq_addr  = pc + XLEN'(4);
   assign off_bytes = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
   assign br_addr   = seq_addr + off_bytes;

   generate
      if (REGION_W > 0) begin : g_region
         assign jabs_addr = {seq_addr[XLEN-1 -: REGION_W], jf, 2'b00};
      end else begin : g_flat
         assign jabs_addr = {jf, 2'b00};
      end
   endgenerate
endmodule

// File: rtl/npc_link.sv
module npc_link
   import npc_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int RIDX_W   = 5,
   parameter int LINK_REG = 31
) (
   input  link_e              sel,
   input  logic [RIDX_W-1:0]  rd,
   input  logic [XLEN-1:0]    ret_addr,
   output logic [XLEN-1:0]    addr,
   output logic               we,
   output logic [RIDX_W-1:0]  dst
);
   assign addr = ret_addr;

   always_comb begin
      case (sel)
         LNK_R31: begin we = 1'b1; dst = RIDX_W'(LINK_REG); end
         LNK_RD:  begin we = 1'b1; dst = rd;                end
         default: begin we = 1'b0; dst = '0;                end
      endcase
   end
endmodule

// File: rtl/npc_pcreg.sv
module npc_pcreg #(
   parameter int              XLEN       = 32,
   parameter logic [XLEN-1:0] RESET_ADDR = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             hold,
   input  logic [XLEN-1:0]  d,
   output logic [XLEN-1:0]  q
);
   always_ff @(posedge clk) begin
      if (rst)        q <= RESET_ADDR;
      else if (!hold) q <= d;
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          OFF_W      = 16,
   parameter int          JF_W       = 26,
   parameter int          RIDX_W     = 5,
   parameter int          LINK_REG   = 31,
   parameter int          EQ_STYLE   = 0,
   parameter logic [31:0] RESET_ADDR = 32'h0040_0000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stall,
   input  logic [1:0]        flow_kind,
   input  logic [2:0]        br_cond,
   input  logic [1:0]        link_sel,
   input  logic [RIDX_W-1:0] rd_idx,
   input  logic [OFF_W-1:0]  br_off,
   input  logic [JF_W-1:0]   jmp_field,
   input  logic [XLEN-1:0]   rs_val,
   input  logic [XLEN-1:0]   rt_val,
   output logic [XLEN-1:0]   pc_q,
   output logic [XLEN-1:0]   next_pc,
   output logic              taken,
   output logic              misaligned,
   output logic [XLEN-1:0]   link_addr,
   output logic              link_we,
   output logic [RIDX_W-1:0] link_dst
);
   localparam logic [XLEN-1:0] RST_PC = XLEN'(RESET_ADDR);

   generate
      if (XLEN < OFF_W + 2)         begin : g_bad_off  $error("XLEN too small for offset"); end
      if (XLEN < JF_W + 2)          begin : g_bad_jf   $error("XLEN too small for jump field"); end
      if (LINK_REG >= (1 << RIDX_W)) begin : g_bad_lnk $error("LINK_REG out of range"); end
      if (RESET_ADDR[1:0] != 2'b00) begin : g_bad_rst  $error("RESET_ADDR not word aligned"); end
   endgenerate

   flow_e           kind;
   logic            cond_hit;
   logic [XLEN-1:0] seq_addr;
   logic [XLEN-1:0] br_addr;
   logic [XLEN-1:0] jabs_addr;

   assign kind = flow_e'(flow_kind);

   npc_cond #(.XLEN(XLEN), .EQ_STYLE(EQ_STYLE)) cond_i (
      .cond (cond_e'(br_cond)),
      .rs   (rs_val),
      .rt   (rt_val),
      .hit  (cond_hit)
   );

   npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JF_W(JF_W)) tgt_i (
      .pc        (pc_q),
      .off       (br_off),
      .jf        (jmp_field),
      .seq_addr  (seq_addr),
      .br_addr   (br_addr),
      .jabs_addr (jabs_addr)
   );

   npc_link #(.XLEN(XLEN), .RIDX_W(RIDX_W), .LINK_REG(LINK_REG)) link_i (
      .sel      (link_e'(link_sel)),
      .rd       (rd_idx),
      .ret_addr (seq_addr),
      .addr     (link_addr),
      .we       (link_we),
      .dst      (link_dst)
   );

   always_comb begin
      case (kind)
         FLOW_BR:   begin taken = cond_hit; next_pc = cond_hit ? br_addr : seq_addr; end
         FLOW_JABS: begin taken = 1'b1;     next_pc = jabs_addr; end
         FLOW_JREG: begin taken = 1'b1;     next_pc = rs_val;    end
         default:   begin taken = 1'b0;     next_pc = seq_addr;  end
      endcase
   end

   assign misaligned = taken & (|next_pc[1:0]);

   npc_pcreg #(.XLEN(XLEN), .RESET_ADDR(RST_PC)) pc_i (
      .clk  (clk),
      .rst  (rst),
      .hold (stall),
      .d    (next_pc),
      .q    (pc_q)
   );
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int          XLEN       = 32,
   parameter logic [31:0] RESET_ADDR = 32'h0040_0000
) (
   input logic            clk,
   input logic            rst,
   input logic            stall,
   input logic [1:0]      flow_kind,
   input logic [XLEN-1:0] pc_q,
   input logic [XLEN-1:0] next_pc,
   input logic            taken,
   input logic            misaligned,
   input logic [XLEN-1:0] link_addr,
   input logic            link_we
);
   a_r1_reset_loads: assert property (@(posedge clk)
      rst |=> (pc_q == XLEN'(RESET_ADDR)));

   a_r2_stall_holds: assert property (@(posedge clk) disable iff (rst)
      stall |=> $stable(pc_q));

   a_r3_advance: assert property (@(posedge clk) disable iff (rst)
      !stall |=> (pc_q == $past(next_pc)));

   a_r4_seq_step: assert property (@(posedge clk) disable iff (rst)
      (flow_kind == 2'd0) |-> (!taken && next_pc == pc_q + XLEN'(4)));

   a_r9_link_return: assert property (@(posedge clk) disable iff (rst)
      link_we |-> (link_addr == pc_q + XLEN'(4)));

   a_r10_flag_needs_taken: assert property (@(posedge clk) disable iff (rst)
      misaligned |-> (taken && next_pc[1:0] != 2'b00));
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .RESET_ADDR(RESET_ADDR)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .stall      (stall),
   .flow_kind  (flow_kind),
   .pc_q       (pc_q),
   .next_pc    (next_pc),
   .taken      (taken),
   .misaligned (misaligned),
   .link_addr  (link_addr),
   .link_we    (link_we)
);

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        stall = 1'b0;
   logic [1:0]  flow_kind = '0;
   logic [2:0]  br_cond = '0;
   logic [1:0]  link_sel = '0;
   logic [4:0]  rd_idx = '0;
   logic [15:0] br_off = '0;
   logic [25:0] jmp_field = '0;
   logic [31:0] rs_val = '0;
   logic [31:0] rt_val = '0;
   logic [31:0] pc_q, next_pc, link_addr;
   logic        taken, misaligned, link_we;
   logic [4:0]  link_dst;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   npc_unit dut_i (
      .clk(clk), .rst(rst), .stall(stall), .flow_kind(flow_kind),
      .br_cond(br_cond), .link_sel(link_sel), .rd_idx(rd_idx),
      .br_off(br_off), .jmp_field(jmp_field), .rs_val(rs_val),
      .rt_val(rt_val), .pc_q(pc_q), .next_pc(next_pc), .taken(taken),
      .misaligned(misaligned), .link_addr(link_addr), .link_we(link_we),
      .link_dst(link_dst)
   );

   typedef struct packed {
      logic [31:0] pc;
      logic [1:0]  kind;
      logic [2:0]  cond;
      logic [1:0]  lsel;
      logic [4:0]  rd;
      logic [15:0] off;
      logic [25:0] jf;
      logic [31:0] rs;
      logic [31:0] rt;
      logic [31:0] enext;
      logic        etaken;
      logic        emis;
      logic        ewe;
      logic [4:0]  edst;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      '{32'h0040_0000, 2'd0, 3'd0, 2'd0, 5'd0, 16'hFFFF, 26'h3FF_FFFF, 32'hDEAD_BEEF, 32'h0, 32'h0040_0004, 1'b0, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0000, 2'd1, 3'd0, 2'd0, 5'd0, 16'h0003, 26'h0, 32'd5, 32'd5, 32'h0040_0010, 1'b1, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0000, 2'd1, 3'd0, 2'd0, 5'd0, 16'h0003, 26'h0, 32'd5, 32'd6, 32'h0040_0004, 1'b0, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0100, 2'd1, 3'd1, 2'd0, 5'd0, 16'hFFFE, 26'h0, 32'd1, 32'd2, 32'h0040_00FC, 1'b1, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0100, 2'd1, 3'd1, 2'd0, 5'd0, 16'hFFFE, 26'h0, 32'd3, 32'd3, 32'h0040_0104, 1'b0, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0000, 2'd1, 3'd2, 2'd0, 5'd0, 16'h0010, 26'h0, 32'h0, 32'h0, 32'h0040_0044, 1'b1, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0000, 2'd1, 3'd2, 2'd0, 5'd0, 16'h0010, 26'h0, 32'h8000_0000, 32'h0, 32'h0040_0044, 1'b1, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0000, 2'd1, 3'd2, 2'd0, 5'd0, 16'h0010, 26'h0, 32'h1, 32'h0, 32'h0040_0004, 1'b0, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0000, 2'd1, 3'd3, 2'd0, 5'd0, 16'h0001, 26'h0, 32'h0, 32'h0, 32'h0040_0004, 1'b0, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0000, 2'd1, 3'd3, 2'd0, 5'd0, 16'h0001, 26'h0, 32'd7, 32'h0, 32'h0040_0008, 1'b1, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0000, 2'd1, 3'd4, 2'd0, 5'd0, 16'h0002, 26'h0, 32'h8000_0000, 32'h0, 32'h0040_000C, 1'b1, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0000, 2'd1, 3'd4, 2'd1, 5'd0, 16'h0002, 26'h0, 32'h1, 32'h0, 32'h0040_0004, 1'b0, 1'b0, 1'b1, 5'd31},
      '{32'h0040_0000, 2'd1, 3'd5, 2'd1, 5'd0, 16'h0004, 26'h0, 32'h0, 32'h0, 32'h0040_0014, 1'b1, 1'b0, 1'b1, 5'd31},
      '{32'h0040_0000, 2'd1, 3'd5, 2'd0, 5'd0, 16'h0004, 26'h0, 32'hFFFF_FFFF, 32'h0, 32'h0040_0004, 1'b0, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0000, 2'd1, 3'd6, 2'd0, 5'd0, 16'h0004, 26'h0, 32'h0, 32'h0, 32'h0040_0004, 1'b0, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0000, 2'd1, 3'd0, 2'd0, 5'd0, 16'h7FFF, 26'h0, 32'h0, 32'h0, 32'h0042_0000, 1'b1, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0000, 2'd1, 3'd0, 2'd0, 5'd0, 16'h8000, 26'h0, 32'h0, 32'h0, 32'h003E_0004, 1'b1, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0000, 2'd2, 3'd0, 2'd1, 5'd0, 16'h0, 26'h010_0003, 32'h0, 32'h0, 32'h0040_000C, 1'b1, 1'b0, 1'b1, 5'd31},
      '{32'h0FFF_FFFC, 2'd2, 3'd0, 2'd0, 5'd0, 16'h0, 26'h000_0001, 32'h0, 32'h0, 32'h1000_0004, 1'b1, 1'b0, 1'b0, 5'd0},
      '{32'hF000_0000, 2'd2, 3'd0, 2'd0, 5'd0, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFC, 1'b1, 1'b0, 1'b0, 5'd0},
      '{32'h0040_0000, 2'd3, 3'd0, 2'd2, 5'd9, 16'h0, 26'h0, 32'h1234_5678, 32'h0, 32'h1234_5678, 1'b1, 1'b0, 1'b1, 5'd9},
      '{32'h0040_0000, 2'd3, 3'd0, 2'd3, 5'd9, 16'h0, 26'h0, 32'h0040_0002, 32'h0, 32'h0040_0002, 1'b1, 1'b1, 1'b0, 5'd0}
   };

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic place_pc(input logic [31:0] target);
      @(negedge clk);
      stall = 1'b0; flow_kind = 2'd3; link_sel = 2'd0; rs_val = target;
      @(posedge clk);
   endtask

   initial begin : watchdog
      #1_000_000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      repeat (2) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      #1 chk("R1", "pc after reset", pc_q, 32'h0040_0000);

      foreach (VECS[i]) begin
         place_pc(VECS[i].pc);
         @(negedge clk);
         flow_kind = VECS[i].kind; br_cond = VECS[i].cond; link_sel = VECS[i].lsel;
         rd_idx = VECS[i].rd; br_off = VECS[i].off; jmp_field = VECS[i].jf;
         rs_val = VECS[i].rs; rt_val = VECS[i].rt;
         #2;
         // R4 R5 R6 R7 R8: target selection
         chk("R5/R6/R7/R8", "next_pc", next_pc, VECS[i].enext);
         chk("R11", "taken", {31'b0, taken}, {31'b0, VECS[i].etaken});
         chk("R10", "misaligned", {31'b0, misaligned}, {31'b0, VECS[i].emis});
         chk("R9", "link_we", {31'b0, link_we}, {31'b0, VECS[i].ewe});
         if (VECS[i].ewe) begin
            chk("R9", "link_dst", {27'b0, link_dst}, {27'b0, VECS[i].edst});
            chk("R9", "link_addr", link_addr, VECS[i].pc + 32'd4);
         end
         @(posedge clk); #1;
         chk("R3", "pc after edge", pc_q, VECS[i].enext);
      end

      // R4: sequential ignores register and field inputs
      place_pc(32'h0000_1000);
      @(negedge clk);
      flow_kind = 2'd0; br_cond = 3'd1; rs_val = 32'h1; rt_val = 32'h2; link_sel = 2'd0;
      #2 chk("R4", "seq next_pc", next_pc, 32'h0000_1004);
      chk("R4", "seq taken", {31'b0, taken}, 32'd0);

      // R2: stall freezes pc
      @(negedge clk);
      flow_kind = 2'd3; rs_val = 32'h0000_8000; stall = 1'b1;
      @(posedge clk); #1 chk("R2", "stalled pc", pc_q, 32'h0000_1004);
      @(posedge clk); #1 chk("R2", "stalled pc second edge", pc_q, 32'h0000_1004);
      @(negedge clk); stall = 1'b0;
      @(posedge clk); #1 chk("R3", "pc after release", pc_q, 32'h0000_8000);

      // R1: reset wins over stall
      @(negedge clk); stall = 1'b1; rst = 1'b1;
      @(posedge clk); #1 chk("R1", "reset during stall", pc_q, 32'h0040_0000);
      @(negedge clk); rst = 1'b0; stall = 1'b0;

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule